// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block joins two 8-bit buses, A and B, and moves data between them in either direction. Each direction has its own storage register with its own capture strobe. A per-direction select input decides whether the far bus receives the live value from the near bus or the value held in that direction's register. Two independent output enables decide whether each side drives its bus: the B-side enable is active high and the A-side enable is active low. Together these give four modes of bus management: live transfer A to B, live transfer B to A, storing either bus, and driving stored data onto either bus.

The bus pins are split into input, output and output-enable signals so that the block can be synthesized, and the tristate pads sit outside it. An input-valid flag for each side tells the block whether an external driver is present. When the flag is low, a keeper on that side supplies the last level seen on the line. That level is either the last external value or, if the block itself drives the line, the value it drives. A system clock `clk` samples the capture strobes and updates the keepers. A capture takes place on the first `clk` edge at which a strobe is seen high after being low.

Top module: `regbus_xcvr`

## Requirements
- R1: While `rstN` is low, both storage registers and both keepers are 0. Selecting stored data therefore drives 0, and so does selecting live data with no external driver.
- R2: At a `clk` edge where `storeClkA` is 1 and was 0 at the previous edge, `regA` takes the live A value. This happens whatever the select and enable inputs are.
- R3: At a `clk` edge where `storeClkB` is 1 and was 0 at the previous edge, `regB` takes the live B value. This happens whatever the select and enable inputs are.
- R4: With `selAtoB` = 0, `bOut` equals the live A value. With `selAtoB` = 1, `bOut` equals `regA`.
- R5: With `selBtoA` = 0, `aOut` equals the live B value. With `selBtoA` = 1, `aOut` equals `regB`.
- R6: `bOe` is 1 exactly when `enAtoB` is 1. When `bOe` is 0, `bOut` is don't-care.
- R7: `aOe` is 1 exactly when `enBtoAN` is 0. When `aOe` is 0, `aOut` is don't-care.
- R8: When a side's input-valid flag is 0, its live value is the last level on that line. That level is the last external value, or the value last driven by the block itself if it drove the line.
- R9: With both selects at 0 and both sides enabled, both buses keep the value they held when the external drivers withdrew.
- R10: If a select input changes while the live value equals the stored value, the selected output does not change.
- R11: A strobe that stays high across several `clk` edges captures only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for strobe sampling and keepers |
| rstN | input | 1 | Asynchronous active-low reset |
| storeClkA | input | 1 | Capture strobe for the A-side register |
| storeClkB | input | 1 | Capture strobe for the B-side register |
| selAtoB | input | 1 | 0: live A to B, 1: stored A to B |
| selBtoA | input | 1 | 0: live B to A, 1: stored B to A |
| enAtoB | input | 1 | Active-high enable for the B-side drivers |
| enBtoAN | input | 1 | Active-low enable for the A-side drivers |
| aIn | input | 8 | Value on the A bus from an external driver |
| aInValid | input | 1 | An external driver is present on A |
| bIn | input | 8 | Value on the B bus from an external driver |
| bInValid | input | 1 | An external driver is present on B |
| aOut | output | 8 | Data to drive onto the A bus |
| aOe | output | 1 | Drive enable for the A bus |
| bOut | output | 8 | Data to drive onto the B bus |
| bOe | output | 1 | Drive enable for the B bus |

## Verification
The hardest case to reach is the loop-back hold, where both sides drive each other with no external driver. Each bus then keeps its value only through the keepers. The stimulus first drives A from outside with both sides enabled in live mode, so that B and both keepers take the value. It then drops every external valid flag and checks that both outputs keep that value over further cycles. A similar sequence holds a strobe high while the bus changes underneath it, to show that only the rising edge captures.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

  // Strobes and steering that the control hands to the datapath.
  typedef struct packed {
    logic capA;         // load regA this cycle
    logic capB;         // load regB this cycle
    logic pickStoredA;  // B output takes regA instead of live A
    logic pickStoredB;  // A output takes regB instead of live B
    logic driveA;       // A side drivers on
    logic driveB;       // B side drivers on
  } strobes_t;

endpackage

// File: rtl/regbus_ctrl.sv
module regbus_ctrl
  import regbus_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     storeClkA,
  input  logic     storeClkB,
  input  logic     selAtoB,
  input  logic     selBtoA,
  input  logic     enAtoB,
  input  logic     enBtoAN,
  output strobes_t st
);

  logic prevClkA;
  logic prevClkB;

  // Remember the strobe levels so that only a low-to-high step captures.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevClkA <= 1'b0;
      prevClkB <= 1'b0;
    end else begin
      prevClkA <= storeClkA;
      prevClkB <= storeClkB;
    end
  end

  always_comb begin
    st.capA        = storeClkA & ~prevClkA;
    st.capB        = storeClkB & ~prevClkB;
    st.pickStoredA = selAtoB;
    st.pickStoredB = selBtoA;
    st.driveB      = enAtoB;
    st.driveA      = ~enBtoAN;
  end

endmodule

// File: rtl/regbus_keeper.sv
module regbus_keeper #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] extData,
  input  logic         extValid,
  input  logic [W-1:0] ownData,
  input  logic         ownOe,
  output logic [W-1:0] live
);

  logic [W-1:0] keep;

  // The line level: an external driver wins, otherwise the held level.
  assign live = extValid ? extData : keep;

  // Follow whatever is on the line; the block's own drive counts as well.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         keep <= '0;
    else if (extValid) keep <= extData;
    else if (ownOe)    keep <= ownData;
  end

endmodule

// File: rtl/regbus_dp.sv
module regbus_dp
  import regbus_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobes_t     st,
  input  logic [W-1:0] aIn,
  input  logic         aInValid,
  input  logic [W-1:0] bIn,
  input  logic         bInValid,
  output logic [W-1:0] aOut,
  output logic         aOe,
  output logic [W-1:0] bOut,
  output logic         bOe,
  output logic [W-1:0] liveA,
  output logic [W-1:0] liveB,
  output logic [W-1:0] regA,
  output logic [W-1:0] regB
);

  // Live values come from the keepers, never from this block's own outputs,
  // so the loop-back hold closes through a register.
  regbus_keeper #(.W(W)) u_keepA (
    .clk(clk), .rstN(rstN), .extData(aIn), .extValid(aInValid),
    .ownData(aOut), .ownOe(aOe), .live(liveA)
  );

  regbus_keeper #(.W(W)) u_keepB (
    .clk(clk), .rstN(rstN), .extData(bIn), .extValid(bInValid),
    .ownData(bOut), .ownOe(bOe), .live(liveB)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        regA <= '0;
    else if (st.capA) regA <= liveA;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        regB <= '0;
    else if (st.capB) regB <= liveB;
  end

  always_comb begin
    bOut = st.pickStoredA ? regA : liveA;
    aOut = st.pickStoredB ? regB : liveB;
    bOe  = st.driveB;
    aOe  = st.driveA;
  end

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import regbus_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         storeClkA,
  input  logic         storeClkB,
  input  logic         selAtoB,
  input  logic         selBtoA,
  input  logic         enAtoB,
  input  logic         enBtoAN,
  input  logic [W-1:0] aIn,
  input  logic         aInValid,
  input  logic [W-1:0] bIn,
  input  logic         bInValid,
  output logic [W-1:0] aOut,
  output logic         aOe,
  output logic [W-1:0] bOut,
  output logic         bOe
);

  strobes_t     st;
  logic [W-1:0] liveA;
  logic [W-1:0] liveB;
  logic [W-1:0] regA;
  logic [W-1:0] regB;

  regbus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .storeClkA(storeClkA), .storeClkB(storeClkB),
    .selAtoB(selAtoB), .selBtoA(selBtoA),
    .enAtoB(enAtoB), .enBtoAN(enBtoAN),
    .st(st)
  );

  regbus_dp #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st),
    .aIn(aIn), .aInValid(aInValid), .bIn(bIn), .bInValid(bInValid),
    .aOut(aOut), .aOe(aOe), .bOut(bOut), .bOe(bOe),
    .liveA(liveA), .liveB(liveB), .regA(regA), .regB(regB)
  );

endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         storeClkA,
  input logic         storeClkB,
  input logic         selAtoB,
  input logic         selBtoA,
  input logic         enAtoB,
  input logic         enBtoAN,
  input logic [W-1:0] aOut,
  input logic         aOe,
  input logic [W-1:0] bOut,
  input logic         bOe,
  input logic [W-1:0] liveA,
  input logic [W-1:0] liveB,
  input logic [W-1:0] regA,
  input logic [W-1:0] regB
);

  logic seenA;
  logic seenB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenA <= 1'b0;
      seenB <= 1'b0;
    end else begin
      seenA <= storeClkA;
      seenB <= storeClkB;
    end
  end

  assert_capture_a_R2: assert property (@(posedge clk) disable iff (!rstN)
    (storeClkA && !seenA) |=> (regA == $past(liveA)));

  assert_capture_b_R3: assert property (@(posedge clk) disable iff (!rstN)
    (storeClkB && !seenB) |=> (regB == $past(liveB)));

  assert_held_strobe_R11: assert property (@(posedge clk) disable iff (!rstN)
    (storeClkA && seenA) |=> $stable(regA));

  assert_a_to_b_mux_R4: assert property (@(posedge clk) disable iff (!rstN)
    (bOut == (selAtoB ? regA : liveA)));

  assert_b_to_a_mux_R5: assert property (@(posedge clk) disable iff (!rstN)
    (aOut == (selBtoA ? regB : liveB)));

  assert_b_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (bOe == enAtoB));

  assert_a_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (aOe == !enBtoAN));

  assert_no_select_glitch_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(selAtoB) && $stable(liveA) && $stable(regA) && liveA == regA)
      |-> $stable(bOut));

endmodule

bind regbus_xcvr regbus_xcvr_chk #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .storeClkA(storeClkA), .storeClkB(storeClkB),
  .selAtoB(selAtoB), .selBtoA(selBtoA), .enAtoB(enAtoB), .enBtoAN(enBtoAN),
  .aOut(aOut), .aOe(aOe), .bOut(bOut), .bOe(bOe),
  .liveA(liveA), .liveB(liveB), .regA(regA), .regB(regB)
);

// File: tb/sim_regbus_xcvr.sv
`timescale 1ns/1ps
module sim_regbus_xcvr;

  localparam int W = 8;
  localparam int NV = 14;

  typedef struct packed {
    logic         aV;
    logic [W-1:0] aD;
    logic         bV;
    logic [W-1:0] bD;
    logic         ca;
    logic         cb;
    logic         sAB;
    logic         sBA;
    logic         eAB;
    logic         eBAn;
    logic         xAoe;
    logic [W-1:0] xAout;
    logic         xBoe;
    logic [W-1:0] xBout;
  } vec_t;

  // Stimulus and expected outputs; each row is checked before the next edge.
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h5A, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'h5A},
    '{1'b1, 8'hC3, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'hC3},
    '{1'b1, 8'h11, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'hC3},
    '{1'b1, 8'h22, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'hC3},
    '{1'b1, 8'h22, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00},
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'h22},
    '{1'b0, 8'h00, 1'b1, 8'h9E, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h9E, 1'b0, 8'h00},
    '{1'b0, 8'h00, 1'b1, 8'h47, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h47, 1'b0, 8'h00},
    '{1'b0, 8'h00, 1'b1, 8'h80, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h47, 1'b0, 8'h00},
    '{1'b1, 8'h6D, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h80, 1'b1, 8'h6D},
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h6D, 1'b1, 8'h6D},
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h6D, 1'b1, 8'h6D},
    '{1'b1, 8'h22, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'h22},
    '{1'b1, 8'h22, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'h22}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         storeClkA = 1'b0, storeClkB = 1'b0;
  logic         selAtoB = 1'b0, selBtoA = 1'b0;
  logic         enAtoB = 1'b0, enBtoAN = 1'b1;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic         aInValid = 1'b0, bInValid = 1'b0;
  logic [W-1:0] aOut, bOut;
  logic         aOe, bOe;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  regbus_xcvr #(.W(W)) u0 (
    .clk(clk), .rstN(rstN), .storeClkA(storeClkA), .storeClkB(storeClkB),
    .selAtoB(selAtoB), .selBtoA(selBtoA), .enAtoB(enAtoB), .enBtoAN(enBtoAN),
    .aIn(aIn), .aInValid(aInValid), .bIn(bIn), .bInValid(bInValid),
    .aOut(aOut), .aOe(aOe), .bOut(bOut), .bOe(bOe)
  );

  task automatic check(input string req, input string what,
                       input logic [W-1:0] got, input logic [W-1:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  // Requirement exercised by the data check of each table row.
  function automatic string rowTag(input int i);
    case (i)
      2, 5:        return "R2";
      3:           return "R11";
      6, 7:        return "R5";
      8:           return "R3";
      9:           return "R8";
      10, 11:      return "R9";
      13:          return "R10";
      default:     return "R4";
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      nChecks++;
      nFails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1: reset state, stored and live paths both show 0.
    selAtoB = 1'b1; selBtoA = 1'b1; enAtoB = 1'b1; enBtoAN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "bOut stored in reset", bOut, '0);
    check("R1", "aOut stored in reset", aOut, '0);
    selAtoB = 1'b0; selBtoA = 1'b0;
    #1;
    check("R1", "bOut kept in reset", bOut, '0);
    check("R1", "aOut kept in reset", aOut, '0);
    @(posedge clk);
    #1 rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      #1;
      aInValid = VEC[i].aV;  aIn = VEC[i].aD;
      bInValid = VEC[i].bV;  bIn = VEC[i].bD;
      storeClkA = VEC[i].ca; storeClkB = VEC[i].cb;
      selAtoB = VEC[i].sAB;  selBtoA = VEC[i].sBA;
      enAtoB = VEC[i].eAB;   enBtoAN = VEC[i].eBAn;
      #2;
      check("R7", $sformatf("row %0d aOe", i), W'(aOe), W'(VEC[i].xAoe));
      check("R6", $sformatf("row %0d bOe", i), W'(bOe), W'(VEC[i].xBoe));
      if (VEC[i].xAoe) check(rowTag(i), $sformatf("row %0d aOut", i), aOut, VEC[i].xAout);
      if (VEC[i].xBoe) check(rowTag(i), $sformatf("row %0d bOut", i), bOut, VEC[i].xBout);
    end

    // R1: asynchronous reset in mid-run clears both registers and keepers.
    @(posedge clk);
    #1;
    aInValid = 1'b0; bInValid = 1'b0; storeClkA = 1'b0; storeClkB = 1'b0;
    selAtoB = 1'b1; selBtoA = 1'b1; enAtoB = 1'b1; enBtoAN = 1'b0;
    #1 rstN = 1'b0;
    #1;
    check("R1", "bOut after async reset", bOut, '0);
    check("R1", "aOut after async reset", aOut, '0);
    selAtoB = 1'b0;
    #0.5;
    check("R1", "keeper A after async reset", bOut, '0);
    @(posedge clk);
    #1 rstN = 1'b1;

    // R3: capture of B while both drivers are off, seen later via stored path.
    @(posedge clk);
    #1;
    enAtoB = 1'b0; enBtoAN = 1'b1; bInValid = 1'b1; bIn = 8'hA5; storeClkB = 1'b1;
    @(posedge clk);
    #1;
    bIn = 8'h3C; bInValid = 1'b1; selBtoA = 1'b1; enBtoAN = 1'b0;
    #1;
    check("R3", "regB captured while disabled", aOut, 8'hA5);

    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule